// File: doc/BRIEF.md
# Adaptive Break-Before-Make Gate Sequencer

This block is the digital control core of a synchronous buck half-bridge. It turns one PWM command into two gate-enable commands, one for the high-side switch and one for the low-side (synchronous) switch. It never lets both be on at once. The dead time is not a fixed count. Each switch may turn on only after a comparator reports that the opposite side has actually let go:

- The switch-node-low flag gates the low side.
- The low-side-gate-low flag gates the high side.

A programmable counter adds margin after that report. If the switch node never reports low after the high side turns off, a timeout forces the low side on.

The high-side turn-on margin has a base count plus a trim input. The trim scales linearly, at a ratio of TRIM_NUM/TRIM_DEN cycles per unit, which models a fixed time per unit of trim. Three inputs override the sequencing:

- A supervisor enable blanks both outputs.
- A bootstrap-undervoltage flag blanks the high side.
- A synchronous-enable input blanks the low side for light-load operation.

All comparator flags pass through a two-stage synchronizer. All delays are counted in clock cycles.

Top module: `bbm_gate_seq`

## Requirements
- R1: `hs_o` and `ls_o` are never both 1 in any cycle.
- R2: A PWM fall is registered, and `hs_o` drops HS_OFF_DLY cycles after the state machine sees it. `ls_o` may rise only after the synchronized switch-node-low flag (two flops) is seen, and then LS_ON_DLY cycles later.
- R3: A PWM rise is registered, and `ls_o` drops LS_OFF_DLY cycles after the state machine sees it. `hs_o` may rise only after the synchronized low-side-gate-low flag is seen, and then after the high-side on-delay.
- R4: If the switch-node-low flag is not seen within LX_TMO cycles after `hs_o` drops, `ls_o` is forced to 1. It stays 1 until the next PWM rise, whatever the flag does.
- R5: The high-side on-delay equals HS_ON_DLY + floor(`hs_trim_i` * TRIM_NUM / TRIM_DEN) cycles.
- R6: While `sync_en_i` is 0, `ls_o` is 0 from the next cycle. When `sync_en_i` returns to 1 in a low-side-on phase, `ls_o` rises on the next cycle.
- R7: While the synchronized bootstrap-undervoltage flag is 1, `hs_o` is 0, three cycles after the raw input changes. When the flag clears, `hs_o` resumes, also after three cycles.
- R8: While `en_i` is 0, both outputs are 0 from the next cycle, and PWM edges are ignored. When `en_i` returns to 1, the sequencer starts from the phase the current PWM level selects, waiting on the matching flag.
- R9: A PWM edge that arrives during a dead-time wait, or during a turn-on delay, aborts it. The opposite sequence then starts from its flag wait, and the aborted switch never turns on.
- R10: During reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Supervisor enable; 0 forces both outputs off |
| pwm_i | input | 1 | PWM command; 1 requests high side, 0 low side |
| sync_en_i | input | 1 | Synchronous-switch enable; 0 holds low side off |
| lx_low_i | input | 1 | Switch node below threshold (asynchronous) |
| lsg_low_i | input | 1 | Low-side gate below threshold (asynchronous) |
| bst_uv_i | input | 1 | Bootstrap supply undervoltage (asynchronous) |
| hs_trim_i | input | TRIM_W | Extra high-side on-delay trim |
| hs_o | output | 1 | High-side gate enable |
| ls_o | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with short delays: two-cycle turn-off, three-cycle low-side margin, four-cycle high-side base and a twelve-cycle switch-node timeout. At these values the timeout path, and a dead-time abort, both complete within a few tens of cycles. The trim ratio is kept at 6/25 with a 6-bit trim, so the trim values 50 and 63 give 12 and 15 extra cycles. This exercises the floor of the scaling. Every output edge is predicted to the exact cycle from the register counts stated in the requirements.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HS_ON,
    ST_HS_OFF,
    ST_WAIT_LX,
    ST_LS_DLY,
    ST_LS_ON,
    ST_LS_OFF,
    ST_WAIT_LSG,
    ST_HS_DLY
  } seq_st_e;

  localparam int unsigned FLG_LX  = 0;
  localparam int unsigned FLG_LSG = 1;
  localparam int unsigned FLG_UV  = 2;
  localparam int unsigned NFLG    = 3;

  function automatic logic hs_phase(seq_st_e s);
    return (s == ST_HS_ON) || (s == ST_HS_OFF);
  endfunction

  function automatic logic ls_phase(seq_st_e s);
    return (s == ST_LS_ON) || (s == ST_LS_OFF);
  endfunction
endpackage

// File: rtl/bbm_sync.sv
module bbm_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bbm_trim.sv
module bbm_trim #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned TRIM_W    = 6,
  parameter int unsigned HS_ON_DLY = 6,
  parameter int unsigned TRIM_NUM  = 6,
  parameter int unsigned TRIM_DEN  = 25
) (
  input  logic [TRIM_W-1:0] trim_i,
  output logic [CNT_W-1:0]  lim_o
);
  localparam int unsigned NUM_W  = $clog2(TRIM_NUM + 1);
  localparam int unsigned PROD_W = TRIM_W + NUM_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] extra;

  assign prod = PROD_W'(trim_i) * PROD_W'(TRIM_NUM);

  if (TRIM_DEN == 1) begin : g_nodiv
    assign extra = prod;
  end else begin : g_div
    assign extra = prod / PROD_W'(TRIM_DEN);
  end

  assign lim_o = CNT_W'(HS_ON_DLY) + CNT_W'(extra);
endmodule

// File: rtl/bbm_seq.sv
module bbm_seq
  import bbm_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned HS_OFF_DLY = 4,
  parameter int unsigned LS_OFF_DLY = 6,
  parameter int unsigned LS_ON_DLY  = 6,
  parameter int unsigned LX_TMO     = 84
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pwm_i,
  input  logic             sync_en_i,
  input  logic             lx_low_i,
  input  logic             lsg_low_i,
  input  logic             bst_uv_i,
  input  logic [CNT_W-1:0] hs_on_lim_i,
  output logic             hs_o,
  output logic             ls_o
);
  localparam logic [CNT_W-1:0] HS_OFF_L = CNT_W'(HS_OFF_DLY);
  localparam logic [CNT_W-1:0] LS_OFF_L = CNT_W'(LS_OFF_DLY);
  localparam logic [CNT_W-1:0] LS_ON_L  = CNT_W'(LS_ON_DLY);
  localparam logic [CNT_W-1:0] LX_TMO_L = CNT_W'(LX_TMO);

  seq_st_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             pwm_q, done, hs_q, ls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_i;
  end

  always_comb begin
    unique case (state_q)
      ST_HS_OFF:  lim = HS_OFF_L;
      ST_LS_OFF:  lim = LS_OFF_L;
      ST_LS_DLY:  lim = LS_ON_L;
      ST_WAIT_LX: lim = LX_TMO_L;
      ST_HS_DLY:  lim = hs_on_lim_i;
      default:    lim = '1;
    endcase
  end

  assign done = ((CNT_W+1)'(cnt_q) + (CNT_W+1)'(1)) == (CNT_W+1)'(lim);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     state_d = pwm_q ? ST_WAIT_LSG : ST_WAIT_LX;
      ST_HS_ON:    if (!pwm_q) state_d = ST_HS_OFF;
      ST_HS_OFF:   if (pwm_q) state_d = ST_HS_ON;
                   else if (done) state_d = ST_WAIT_LX;
      ST_WAIT_LX:  if (pwm_q) state_d = ST_WAIT_LSG;
                   else if (lx_low_i) state_d = ST_LS_DLY;
                   else if (done) state_d = ST_LS_ON; // timeout: force low side
      ST_LS_DLY:   if (pwm_q) state_d = ST_WAIT_LSG;
                   else if (done) state_d = ST_LS_ON;
      ST_LS_ON:    if (pwm_q) state_d = ST_LS_OFF;
      ST_LS_OFF:   if (!pwm_q) state_d = ST_LS_ON;
                   else if (done) state_d = ST_WAIT_LSG;
      ST_WAIT_LSG: if (!pwm_q) state_d = ST_WAIT_LX;
                   else if (lsg_low_i) state_d = ST_HS_DLY;
      ST_HS_DLY:   if (!pwm_q) state_d = ST_WAIT_LX;
                   else if (done) state_d = ST_HS_ON;
      default:     state_d = ST_IDLE;
    endcase
    if (!en_i) state_d = ST_IDLE;
  end

  always_comb begin
    if (state_d != state_q) cnt_d = '0;
    else if (state_q inside {ST_HS_OFF, ST_LS_OFF, ST_LS_DLY, ST_WAIT_LX, ST_HS_DLY})
      cnt_d = cnt_q + CNT_W'(1);
    else cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hs_q    <= en_i & ~bst_uv_i & hs_phase(state_d);
      ls_q    <= en_i & sync_en_i & ls_phase(state_d);
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  p_no_overlap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_q && ls_q));
  p_ls_dead_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_q) |-> $past(!hs_q));
  p_hs_dead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> $past(!ls_q));
  p_hs_needs_pwm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> $past(pwm_q));
  p_sync_dis_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_en_i |=> !ls_q);
  p_bst_uv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bst_uv_i |=> !hs_q);
  p_en_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(hs_q || ls_q));
endmodule

// File: rtl/bbm_gate_seq.sv
module bbm_gate_seq
  import bbm_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned TRIM_W     = 6,
  parameter int unsigned HS_OFF_DLY = 4,
  parameter int unsigned LS_OFF_DLY = 6,
  parameter int unsigned LS_ON_DLY  = 6,
  parameter int unsigned HS_ON_DLY  = 6,
  parameter int unsigned LX_TMO     = 84,
  parameter int unsigned TRIM_NUM   = 6,
  parameter int unsigned TRIM_DEN   = 25,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pwm_i,
  input  logic              sync_en_i,
  input  logic              lx_low_i,
  input  logic              lsg_low_i,
  input  logic              bst_uv_i,
  input  logic [TRIM_W-1:0] hs_trim_i,
  output logic              hs_o,
  output logic              ls_o
);
  logic [NFLG-1:0]  flg_raw, flg_s;
  logic [CNT_W-1:0] hs_on_lim;

  always_comb begin
    flg_raw         = '0;
    flg_raw[FLG_LX]  = lx_low_i;
    flg_raw[FLG_LSG] = lsg_low_i;
    flg_raw[FLG_UV]  = bst_uv_i;
  end

  bbm_sync #(.W(NFLG), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (flg_raw),
    .q_o   (flg_s)
  );

  bbm_trim #(
    .CNT_W(CNT_W), .TRIM_W(TRIM_W), .HS_ON_DLY(HS_ON_DLY),
    .TRIM_NUM(TRIM_NUM), .TRIM_DEN(TRIM_DEN)
  ) u_trim (
    .trim_i(hs_trim_i),
    .lim_o (hs_on_lim)
  );

  bbm_seq #(
    .CNT_W(CNT_W), .HS_OFF_DLY(HS_OFF_DLY), .LS_OFF_DLY(LS_OFF_DLY),
    .LS_ON_DLY(LS_ON_DLY), .LX_TMO(LX_TMO)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .pwm_i      (pwm_i),
    .sync_en_i  (sync_en_i),
    .lx_low_i   (flg_s[FLG_LX]),
    .lsg_low_i  (flg_s[FLG_LSG]),
    .bst_uv_i   (flg_s[FLG_UV]),
    .hs_on_lim_i(hs_on_lim),
    .hs_o       (hs_o),
    .ls_o       (ls_o)
  );
endmodule

// File: tb/bbm_gate_seq_tb.sv
`timescale 1ns/1ps
module bbm_gate_seq_tb;
  localparam int TRIM_W = 6;
  localparam int HSOFF = 2, LSOFF = 2, LSON = 3, HSON = 4, TMO = 12;
  localparam int TNUM = 6, TDEN = 25;

  typedef struct {
    int    cyc;
    bit    hs;
    bit    ls;
    string req;
  } ev_t;

  logic clk = 0, rst_ni = 0;
  logic en = 0, pwm = 0, sync_en = 1, lx = 0, lsg = 0, uv = 0;
  logic [TRIM_W-1:0] trim = '0;
  logic hs_o, ls_o;

  int cyc = 0, checks = 0, errors = 0, overlaps = 0;
  ev_t sb[$];
  bit hs_p = 0, ls_p = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bbm_gate_seq #(
    .CNT_W(8), .TRIM_W(TRIM_W), .HS_OFF_DLY(HSOFF), .LS_OFF_DLY(LSOFF),
    .LS_ON_DLY(LSON), .HS_ON_DLY(HSON), .LX_TMO(TMO),
    .TRIM_NUM(TNUM), .TRIM_DEN(TDEN), .SYNC_STG(2)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .pwm_i(pwm), .sync_en_i(sync_en),
    .lx_low_i(lx), .lsg_low_i(lsg), .bst_uv_i(uv), .hs_trim_i(trim),
    .hs_o(hs_o), .ls_o(ls_o)
  );

  // monitor: every output change must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (hs_o && ls_o) overlaps++;
      if (hs_o !== hs_p || ls_o !== ls_p) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL unexpected edge at cyc %0d: actual hs=%0b ls=%0b expected no change", cyc, hs_o, ls_o);
        end else begin
          ev_t e;
          e = sb.pop_front();
          if (e.cyc != cyc || e.hs != hs_o || e.ls != ls_o) begin
            errors++;
            $display("FAIL %s: actual cyc=%0d hs=%0b ls=%0b expected cyc=%0d hs=%0b ls=%0b",
                     e.req, cyc, hs_o, ls_o, e.cyc, e.hs, e.ls);
          end
        end
        hs_p = hs_o;
        ls_p = ls_o;
      end
    end
  end

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int c, input bit h, input bit l, input string r);
    ev_t e;
    e.cyc = c; e.hs = h; e.ls = l; e.req = r;
    sb.push_back(e);
  endtask

  task automatic chk(input bit ok, input string r, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s (actual hs=%0b ls=%0b)", r, what, hs_o, ls_o);
    end
  endtask

  task automatic drained(input string r);
    chk(sb.size() == 0, r, $sformatf("expected 0 pending edges, actual %0d", sb.size()));
    sb.delete();
  endtask

  // high side on -> low side on, flag given 5 cycles after the PWM fall
  task automatic do_fall(input string r);
    int c;
    c = cyc; pwm = 0;
    push(c + 2 + HSOFF, 0, 0, r);
    adv(5); lx = 1; lsg = 0;
    push(c + 5 + 3 + LSON, 0, 1, r);
    adv(10);
    drained(r);
  endtask

  // low side on -> high side on
  task automatic do_rise(input int hsd, input string r);
    int c;
    c = cyc; pwm = 1; lx = 0;
    push(c + 2 + LSOFF, 0, 0, r);
    adv(5); lsg = 1;
    push(c + 5 + 3 + hsd, 1, 0, r);
    adv(hsd + 8);
    drained(r);
  endtask

  initial begin
    int c;
    adv(3);
    chk(hs_o == 0 && ls_o == 0, "R10", "outputs expected 0 in reset");
    rst_ni = 1;
    adv(2);
    chk(hs_o == 0 && ls_o == 0, "R10", "outputs expected 0 after reset while disabled");

    // start-up into the high-side phase
    pwm = 1; lsg = 1; adv(4);
    c = cyc; en = 1;
    push(c + 2 + HSON, 1, 0, "R8");
    adv(12); drained("R8");

    do_fall("R2");
    do_rise(HSON, "R3");

    // trim: floor(trim*6/25) extra cycles
    trim = 6'd50;
    do_fall("R5");
    do_rise(HSON + (50 * TNUM) / TDEN, "R5");

    // timeout forces the low side on
    c = cyc; pwm = 0;
    push(c + 2 + HSOFF, 0, 0, "R4");
    push(c + 2 + HSOFF + TMO, 0, 1, "R4");
    adv(4 + TMO + 3);
    drained("R4");
    lx = 1; lsg = 0; adv(6);
    chk(ls_o == 1 && hs_o == 0, "R4", "forced low side expected to stay on (hs=0 ls=1)");
    do_rise(HSON + (50 * TNUM) / TDEN, "R4");

    // synchronous switch disabled
    trim = '0;
    sync_en = 0;
    c = cyc; pwm = 0;
    push(c + 2 + HSOFF, 0, 0, "R6");
    adv(5); lx = 1; lsg = 0; adv(10);
    chk(ls_o == 0, "R6", "low side expected held off");
    drained("R6");
    c = cyc; sync_en = 1;
    push(c + 1, 0, 1, "R6");
    adv(3); drained("R6");
    do_rise(HSON, "R6");

    // bootstrap undervoltage
    c = cyc; uv = 1;
    push(c + 3, 0, 0, "R7");
    adv(6);
    chk(hs_o == 0, "R7", "high side expected off under bootstrap UV");
    c = cyc; uv = 0;
    push(c + 3, 1, 0, "R7");
    adv(5); drained("R7");

    // global enable from high-side phase
    c = cyc; en = 0;
    push(c + 1, 0, 0, "R8");
    adv(4); pwm = 0; adv(4);
    chk(hs_o == 0 && ls_o == 0, "R8", "both expected off while disabled despite PWM edge");
    pwm = 1; adv(2);
    c = cyc; en = 1;
    push(c + 2 + HSON, 1, 0, "R8");
    adv(8); drained("R8");
    // global enable from low-side phase
    do_fall("R8");
    c = cyc; en = 0;
    push(c + 1, 0, 0, "R8");
    adv(3);
    c = cyc; en = 1;
    push(c + 2 + LSON, 0, 1, "R8");
    adv(8); drained("R8");
    do_rise(HSON, "R8");

    // abort during the low-side-gate wait
    do_fall("R9");
    c = cyc; pwm = 1; lx = 0;
    push(c + 2 + LSOFF, 0, 0, "R9");
    adv(6);
    c = cyc; pwm = 0; lx = 1;
    push(c + 3 + LSON, 0, 1, "R9");
    adv(10); drained("R9");

    // abort during the high-side on-delay (19 cycles with trim 63)
    trim = 6'd63;
    c = cyc; pwm = 1; lx = 0;
    push(c + 2 + LSOFF, 0, 0, "R9");
    adv(5); lsg = 1; adv(4);
    pwm = 0; lx = 1; lsg = 0;
    push(c + 9 + 3 + LSON, 0, 1, "R9");
    adv(25);
    chk(hs_o == 0 && ls_o == 1, "R9", "aborted high side expected never on (hs=0 ls=1)");
    drained("R9");

    chk(overlaps == 0, "R1", $sformatf("overlap cycles actual %0d expected 0", overlaps));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule